// File: doc/BRIEF.md
# APB Address-Decode Integrity Monitor

This block sits beside an APB address decoder and watches, without driving anything, the requester-side signals (select, enable, ready, address) together with the per-subordinate select vector that the decoder produces. It holds its own copy of the address map as parameters. Each window is a power-of-two size at a base aligned to that size. From this copy it works out which subordinate the current address should reach.

Every cycle it sorts the observed decode into one of several failure classes:
- two or more selects at once;
- no select for an address the map owns;
- a single select that points at the wrong subordinate;
- a select raised while no transfer is in progress;
- an address that moves between the setup phase and the completion of its access phase.

Each class has its own error flag. The flags stay set until reset. The address of the first offending cycle is captured for debug. Integrators attach the monitor in simulation or emulation builds to catch decoder bugs early: overlapping ranges, holes, aliasing from a partial compare, and ungated selects.

Top module: `apb_decode_monitor`

## Requirements
- R1: When `psel` is high and two or more bits of `slv_sel` are high, `err_overlap` is set.
- R2: When `psel` is high, `slv_sel` is all zero and `paddr` falls inside a mapped window, `err_hole` is set.
- R3: When `psel` is high, `slv_sel` is all zero and `paddr` lies outside every window, no flag is set. Such an address belongs to the default subordinate.
- R4: Window n matches when `(paddr & ~(SIZE[n]-1)) == BASE[n]`, comparing every address bit. When `psel` is high and exactly one bit of `slv_sel` is set but it differs from the expected vector, `err_mistarget` is set. This includes a single select for an unmapped address, such as an alias at 0x1200 with the default map. With the default map, bit n of `slv_sel` is window n, at base n*0x100 and size 0x100.
- R5: When `psel` is low and any bit of `slv_sel` is high, `err_ungated` is set.
- R6: If `paddr` during any access-phase cycle (`psel` and `penable` high) differs from the address seen in that transfer's setup cycle (`psel` high, `penable` low), `err_unstable` is set. The check spans all wait states and stops at the first cycle with `psel`, `penable` and `pready` all high. A new setup phase may carry a new address.
- R7: A flag rises on the clock edge that ends the offending cycle. It then stays high until `presetn` goes low.
- R8: `fail_addr` captures `paddr` from the first offending cycle after reset. Later violations leave it unchanged.
- R9: While `presetn` is low, all flags and `fail_addr` are held at zero and no check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Requester select for the peripheral region |
| penable | input | 1 | Access-phase indicator |
| pready | input | 1 | Completion from the selected subordinate |
| paddr | input | AW | Byte address |
| slv_sel | input | N | Per-subordinate selects from the decoder under watch |
| err_overlap | output | 1 | Sticky: more than one select |
| err_hole | output | 1 | Sticky: no select for a mapped address |
| err_mistarget | output | 1 | Sticky: one select, wrong subordinate |
| err_ungated | output | 1 | Sticky: select active outside a transfer |
| err_unstable | output | 1 | Sticky: address moved during a transfer |
| fail_addr | output | AW | Address of the first violation |

## Verification
Two classifications can land in one cycle. An access-phase cycle can move the address and, in the same cycle, carry a select count or target that is wrong for the new address. The bench provokes this by changing `paddr` to an address where the decoder answers with two selects during the access phase. It then expects both the instability flag and the overlap flag after that one edge, with `fail_addr` holding the moved address. Separately, a later violation of another class is injected after a first one. The bench checks that the new flag joins the old one while the captured address keeps the earlier value.

// File: rtl/apb_decode_monitor.sv
module apb_decode_monitor #(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter logic [N-1:0][AW-1:0] BASE = {32'h0000_0300, 32'h0000_0200, 32'h0000_0100, 32'h0000_0000},
  parameter logic [N-1:0][AW-1:0] SIZE = {32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100}
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pready,
  input  logic [AW-1:0] paddr,
  input  logic [N-1:0]  slv_sel,
  output logic          err_overlap,
  output logic          err_hole,
  output logic          err_mistarget,
  output logic          err_ungated,
  output logic          err_unstable,
  output logic [AW-1:0] fail_addr
);

  logic [N-1:0] exp_sel;

  for (genvar i = 0; i < N; i++) begin : g_win
    localparam logic [AW-1:0] MSK = SIZE[i] - 1'b1;
    if ((SIZE[i] & MSK) != '0 || SIZE[i] == '0) begin : g_bad_size
      $error("window %0d size is not a power of two", i);
    end
    if ((BASE[i] & MSK) != '0) begin : g_bad_base
      $error("window %0d base not aligned to its size", i);
    end
    assign exp_sel[i] = ((paddr & ~MSK) == BASE[i]);
  end

  logic any_sel, one_sel, many_sel;
  assign any_sel  = |slv_sel;
  assign one_sel  = any_sel && ((slv_sel & (slv_sel - 1'b1)) == '0);
  assign many_sel = any_sel && !one_sel;

  logic          armed;
  logic [AW-1:0] setup_addr;
  logic          setup_cyc, access_cyc, done_cyc;
  assign setup_cyc  = psel && !penable;
  assign access_cyc = psel && penable;
  assign done_cyc   = access_cyc && pready;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      armed      <= 1'b0;
      setup_addr <= '0;
    end else if (setup_cyc) begin
      armed      <= 1'b1;
      setup_addr <= paddr;
    end else if (done_cyc || !psel) begin
      armed      <= 1'b0;
    end
  end

  logic v_overlap, v_hole, v_mistarget, v_ungated, v_unstable, v_any, flagged;
  assign v_overlap   = psel && many_sel;
  assign v_hole      = psel && !any_sel && (|exp_sel);
  assign v_mistarget = psel && one_sel && (slv_sel != exp_sel);
  assign v_ungated   = !psel && any_sel;
  assign v_unstable  = armed && access_cyc && (paddr != setup_addr);
  assign v_any       = v_overlap | v_hole | v_mistarget | v_ungated | v_unstable;
  assign flagged     = err_overlap | err_hole | err_mistarget | err_ungated | err_unstable;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      err_overlap   <= 1'b0;
      err_hole      <= 1'b0;
      err_mistarget <= 1'b0;
      err_ungated   <= 1'b0;
      err_unstable  <= 1'b0;
      fail_addr     <= '0;
    end else begin
      err_overlap   <= err_overlap   | v_overlap;
      err_hole      <= err_hole      | v_hole;
      err_mistarget <= err_mistarget | v_mistarget;
      err_ungated   <= err_ungated   | v_ungated;
      err_unstable  <= err_unstable  | v_unstable;
      if (v_any && !flagged) fail_addr <= paddr;
    end
  end

endmodule

// File: rtl/apb_decode_monitor_chk.sv
module apb_decode_monitor_chk #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic [AW-1:0] paddr,
  input logic [N-1:0]  slv_sel,
  input logic [N-1:0]  exp_sel,
  input logic          err_overlap,
  input logic          err_hole,
  input logic          err_mistarget,
  input logic          err_ungated,
  input logic          err_unstable,
  input logic [AW-1:0] fail_addr
);

  p_overlap_flag_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && $countones(slv_sel) > 1) |=> err_overlap);

  p_hole_flag_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && slv_sel == '0 && exp_sel != '0) |=> err_hole);

  p_mistarget_flag_r4: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && $countones(slv_sel) == 1 && slv_sel != exp_sel) |=> err_mistarget);

  p_ungated_flag_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (!psel && slv_sel != '0) |=> err_ungated);

  p_addr_moved_r6: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && $past(psel && !penable) && paddr != $past(paddr)) |=> err_unstable);

  p_sticky_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (err_overlap || err_hole || err_mistarget || err_ungated || err_unstable)
    |=> (err_overlap || err_hole || err_mistarget || err_ungated || err_unstable));

  p_first_addr_kept_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (err_overlap || err_hole || err_mistarget || err_ungated || err_unstable) |=> $stable(fail_addr));

endmodule

bind apb_decode_monitor apb_decode_monitor_chk #(.N(N), .AW(AW)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .paddr(paddr),
  .slv_sel(slv_sel), .exp_sel(exp_sel), .err_overlap(err_overlap), .err_hole(err_hole),
  .err_mistarget(err_mistarget), .err_ungated(err_ungated), .err_unstable(err_unstable),
  .fail_addr(fail_addr)
);

// File: tb/apb_decode_monitor_test.sv
module apb_decode_monitor_test;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pready = 1'b0;
  logic [31:0] paddr = '0;
  logic [3:0]  slv_sel = '0;
  logic err_overlap, err_hole, err_mistarget, err_ungated, err_unstable;
  logic [31:0] fail_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 pclk = ~pclk;

  apb_decode_monitor uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pready(pready),
    .paddr(paddr), .slv_sel(slv_sel), .err_overlap(err_overlap), .err_hole(err_hole),
    .err_mistarget(err_mistarget), .err_ungated(err_ungated), .err_unstable(err_unstable),
    .fail_addr(fail_addr)
  );

  // fields: psel | paddr | slv_sel | flags {unstable,ungated,mistarget,hole,overlap} | tag
  localparam int NV = 12;
  localparam logic [1+32+4+5-1:0] VEC [NV] = '{
    {1'b1, 32'h0000_0000, 4'b0001, 5'b00000},  // R4 good decode, first address
    {1'b1, 32'h0000_01FF, 4'b0010, 5'b00000},  // R4 last address of window 1
    {1'b1, 32'h0000_0200, 4'b0110, 5'b00001},  // R1 boundary overlap
    {1'b1, 32'h0000_0200, 4'b0000, 5'b00010},  // R2 hole in mapped window
    {1'b1, 32'h0000_0400, 4'b0000, 5'b00000},  // R3 unmapped, default subordinate
    {1'b1, 32'h0000_1200, 4'b0100, 5'b00100},  // R4 alias of window 2
    {1'b1, 32'h0000_0300, 4'b0100, 5'b00100},  // R4 wrong target
    {1'b1, 32'h0000_00FF, 4'b1111, 5'b00001},  // R1 all selects
    {1'b0, 32'h0000_0100, 4'b0010, 5'b01000},  // R5 ungated select
    {1'b0, 32'h0000_0100, 4'b0000, 5'b00000},  // R5 idle, quiet
    {1'b1, 32'h0000_02FC, 4'b0100, 5'b00000},  // R4 good decode, window 2
    {1'b1, 32'h0000_0400, 4'b0001, 5'b00100}   // R4 unmapped but selected
  };

  task automatic drive(input logic s, input logic e, input logic r, input logic [31:0] a, input logic [3:0] v);
    psel = s; penable = e; pready = r; paddr = a; slv_sel = v;
    @(negedge pclk);
  endtask

  task automatic do_reset();
    presetn = 1'b0;
    psel = 0; penable = 0; pready = 0; paddr = '0; slv_sel = '0;
    @(negedge pclk); @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
  endtask

  task automatic check(input string req, input logic [4:0] exp_f, input logic [31:0] exp_a);
    logic [4:0] got;
    got = {err_unstable, err_ungated, err_mistarget, err_hole, err_overlap};
    n_cmp++;
    if (got !== exp_f || fail_addr !== exp_a) begin
      n_bad++;
      $display("FAIL %s: flags=%b addr=%h expected flags=%b addr=%h", req, got, fail_addr, exp_f, exp_a);
    end
  endtask

  initial begin
    @(negedge pclk);
    presetn = 1'b0;
    @(negedge pclk);
    check("R9 in reset", 5'b0, 32'h0);
    drive(1, 0, 0, 32'h200, 4'b0110);
    check("R9 no check during reset", 5'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [4:0] ef;
      do_reset();
      ef = VEC[i][4:0];
      drive(VEC[i][41], 1'b0, 1'b0, VEC[i][40:9], VEC[i][8:5]);
      check($sformatf("R1-5 table vector %0d", i), ef, (ef != 0) ? VEC[i][40:9] : 32'h0);
      drive(0, 0, 0, 32'h0, 4'b0);
      check($sformatf("R7 held after vector %0d", i), ef, (ef != 0) ? VEC[i][40:9] : 32'h0);
    end

    // R6: clean transfers with wait states, then back-to-back with a new address
    do_reset();
    drive(1, 0, 0, 32'h104, 4'b0010);
    drive(1, 1, 0, 32'h104, 4'b0010);
    drive(1, 1, 0, 32'h104, 4'b0010);
    drive(1, 1, 1, 32'h104, 4'b0010);
    drive(1, 0, 0, 32'h208, 4'b0100);
    drive(1, 1, 1, 32'h208, 4'b0100);
    drive(0, 0, 0, 32'h208, 4'b0000);
    check("R6 stable transfers quiet", 5'b0, 32'h0);

    // R6: address moves in a wait state
    do_reset();
    drive(1, 0, 0, 32'h100, 4'b0010);
    drive(1, 1, 0, 32'h100, 4'b0010);
    drive(1, 1, 0, 32'h104, 4'b0010);
    check("R6 address moved in wait state", 5'b10000, 32'h104);

    // R6 + R1 in the same cycle
    do_reset();
    drive(1, 0, 0, 32'h100, 4'b0010);
    drive(1, 1, 1, 32'h200, 4'b0110);
    check("R6 and R1 same cycle", 5'b10001, 32'h200);

    // R7/R8: later violation of another class keeps first address
    do_reset();
    drive(1, 0, 0, 32'h200, 4'b0110);
    drive(0, 0, 0, 32'h0, 4'b0000);
    drive(0, 0, 0, 32'h0, 4'b0000);
    check("R7 overlap sticky", 5'b00001, 32'h200);
    drive(1, 0, 0, 32'h300, 4'b0000);
    check("R8 first address kept", 5'b00011, 32'h200);

    // R9: reset clears everything
    presetn = 1'b0;
    @(negedge pclk);
    check("R9 reset clears", 5'b0, 32'h0);
    presetn = 1'b1;
    drive(0, 0, 0, 32'h0, 4'b0000);
    check("R9 quiet after reset", 5'b0, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge pclk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule